// File: doc/BRIEF.md
# Cascaded Period Timer with Retriggerable One-Shot

This block has two counters that share one clock. The first is a long period counter. It counts down on every cycle and reloads itself, so it marks the end of each period with a trigger that lasts exactly one cycle. The second is a short one-shot counter. Each trigger starts it, and it holds its output high for a programmable number of cycles. Typical uses are a periodic strobe window or a gate pulse whose length can be changed at run time.

The trigger is found by registering the top bit of the period counter in one extra flip-flop and detecting the falling edge of that bit. The counter is not compared against a full-width terminal value. The trigger therefore comes one cycle after the terminal state. The trigger drives the one-shot as a synchronous enable and is never used as a clock.

Top module: `cascade_timer`

## Requirements
- R1: While `rst` is high, `trig_o` and `pulse_o` are 0, and both stay 0 in the first cycle after release. Reset clears the stored period value to 0, so without a load the trigger repeats every 2 cycles.
- R2: The load strobe is sampled at a rising edge together with a value L. `trig_o` is then high in the cycle that begins L+2 edges after that edge.
- R3: With no further strobes, `trig_o` repeats every L+2 cycles, using the last loaded L.
- R4: `trig_o` is high for exactly one cycle at a time. It is never high in two consecutive cycles.
- R5: `pulse_o` goes high in the cycle after a trigger cycle and stays high for exactly N consecutive cycles. N is the value on `pulse_len_i` during the trigger cycle.
- R6: If N is 0 in the trigger cycle, the trigger produces no pulse, and a running pulse ends at that point.
- R7: A trigger that arrives while a pulse is running restarts the pulse at its full new length, so the pulses join without a gap.
- R8: Changes on `pulse_len_i` outside trigger cycles have no effect on a pulse already running.
- R9: A strobe in the terminal cycle, the one just before a trigger, does not suppress that trigger. The new period L+2 counts from the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb_i | input | 1 | Load strobe: restart the period counter with `load_val_i` |
| load_val_i | input | PERIOD_W-1 | Period value L (period is L+2 cycles) |
| pulse_len_i | input | PULSE_W | One-shot length N, sampled in the trigger cycle |
| trig_o | output | 1 | Single-cycle end-of-period trigger |
| pulse_o | output | 1 | One-shot output |

## Verification
The assertions assume that all inputs change only away from the rising clock edge. They also assume that reset is held for at least one edge before the counters are used. The stimulus drives every input shortly after the falling edge and asserts reset for several cycles at the start and once in mid-run. Load values stay small enough that many periods fit into the run. Strobes are rare, so free-running periods dominate. Random lengths from 0 to 15 are changed on every cycle, which covers zero lengths, retriggers and ignored length changes.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int unsigned DEF_PERIOD_W = 28;
  localparam int unsigned DEF_PULSE_W  = 8;
  // Cycles between triggers for a loaded value: guard-bit countdown plus terminal cycle
  localparam int unsigned PERIOD_EXTRA = 2;
endpackage

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_stb,
  input  logic [PERIOD_W-2:0] load_val,
  output logic                msb_o
);
  localparam int unsigned TOP = PERIOD_W - 1;

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-2:0] reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= '0;
    end else if (load_stb) begin
      reload <= load_val;
      cnt    <= {1'b1, load_val};
    end else if (!cnt[TOP]) begin
      cnt    <= {1'b1, reload};
    end else begin
      cnt    <= cnt - 1'b1;
    end
  end

  assign msb_o = cnt[TOP];

  // R3
  terminal_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !cnt[TOP]) |=> (cnt[TOP] && cnt[TOP-1:0] == $past(reload)));
endmodule

// File: rtl/edge_trigger.sv
module edge_trigger (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic trig_o
);
  logic level_d;
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      level_d <= level_i;
      trig_q  <= level_d & ~level_i;
    end
  end

  assign trig_o = trig_q;

  // R4
  trig_single_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);
  // R2
  fall_to_trig_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(level_i) |=> trig_o);
endmodule

// File: rtl/oneshot.sv
module oneshot #(
  parameter int unsigned PULSE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [PULSE_W-1:0] len_i,
  output logic               pulse_o
);
  logic [PULSE_W-1:0] rem;
  logic               out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      out_q <= 1'b0;
    end else if (start_i) begin
      rem   <= len_i;
      out_q <= (len_i != '0);
    end else if (rem != '0) begin
      rem   <= rem - 1'b1;
      out_q <= (rem > 1);
    end
  end

  assign pulse_o = out_q;

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_i != '0) |=> pulse_o);
  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_i == '0) |=> !pulse_o);
  // R7
  restart_full_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (rem == $past(len_i)));
  // R8
  hold_running_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && rem > 1) |=> (pulse_o && rem == $past(rem) - 1'b1));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int unsigned PERIOD_W = DEF_PERIOD_W,
  parameter int unsigned PULSE_W  = DEF_PULSE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_stb_i,
  input  logic [PERIOD_W-2:0] load_val_i,
  input  logic [PULSE_W-1:0]  pulse_len_i,
  output logic                trig_o,
  output logic                pulse_o
);
  logic period_msb;
  logic trig;

  period_counter #(.PERIOD_W(PERIOD_W)) u_period (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb_i),
    .load_val (load_val_i),
    .msb_o    (period_msb)
  );

  edge_trigger u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (period_msb),
    .trig_o  (trig)
  );

  oneshot #(.PULSE_W(PULSE_W)) u_shot (
    .clk     (clk),
    .rst     (rst),
    .start_i (trig),
    .len_i   (pulse_len_i),
    .pulse_o (pulse_o)
  );

  assign trig_o = trig;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!trig_o && !pulse_o));
  // R9
  strobe_keeps_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb_i && !period_msb) |=> trig_o);
endmodule

// File: tb/cascade_timer_test.sv
module cascade_timer_test;
  localparam int PW = 28;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_stb;
  logic [PW-2:0] load_v;
  logic [LW-1:0] len_v;
  logic          trig_o, pulse_o;

  int tests = 0, fails = 0;

  cascade_timer #(.PERIOD_W(PW), .PULSE_W(LW)) uut (
    .clk(clk), .rst(rst), .load_stb_i(load_stb), .load_val_i(load_v),
    .pulse_len_i(len_v), .trig_o(trig_o), .pulse_o(pulse_o)
  );

  always #10 clk = ~clk;

  // Reference model built from the requirements
  int  left, per_l, rem;
  bit  exp_trig, exp_pulse;

  always @(posedge clk) begin
    bit t;
    if (rst) begin
      left = 3; per_l = 0; rem = 0; exp_trig = 0; exp_pulse = 0;
    end else begin
      t = (left == 1);
      if (exp_trig) rem = len_v;            // R5 sampled in trigger cycle
      else if (rem > 0) rem = rem - 1;
      if (load_stb) begin
        per_l = load_v;
        left  = load_v + 2;                 // R2
      end else if (t) left = per_l + 2;     // R3
      else left = left - 1;
      exp_trig  = t;
      exp_pulse = (rem != 0);
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: per-cycle comparison plus measurements
  int  cyc = 0, last_trig = -1, last_interval = 0;
  int  run = 0, last_width = 0, hi_cnt = 0, lo_cnt = 0, consec = 0;
  bit  prev_trig = 0;

  always @(negedge clk) begin
    cyc++;
    chk("R2/R3 trigger", int'(trig_o), int'(exp_trig));
    chk("R5 pulse", int'(pulse_o), int'(exp_pulse));
    if (trig_o && prev_trig) consec++;
    prev_trig = trig_o;
    if (trig_o) begin
      if (last_trig >= 0) last_interval = cyc - last_trig;
      last_trig = cyc;
    end
    if (pulse_o) begin run++; hi_cnt++; end
    else begin
      if (run != 0) last_width = run;
      run = 0; lo_cnt++;
    end
    if (rst) last_trig = -1;
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_load(int l);
    load_stb = 1'b1; load_v = l[PW-2:0];
    tick();
    load_stb = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    rst = 1'b1; load_stb = 1'b0; load_v = '0; len_v = '0;
    tick(3);
    chk("R1 trig in reset", int'(trig_o), 0);
    chk("R1 pulse in reset", int'(pulse_o), 0);
    rst = 1'b0;
    tick();
    chk("R1 trig after release", int'(trig_o), 0);
    chk("R1 pulse after release", int'(pulse_o), 0);
    tick(8);
    chk("R1 default period", last_interval, 2);

    // R2 / R3 / R5: period 7, length 3
    len_v = 8'd3;
    do_load(5);
    tick(30);
    chk("R3 period after load", last_interval, 7);
    chk("R5 pulse width", last_width, 3);

    // R6: zero length gives no pulse
    len_v = 8'd0;
    tick(3);
    hi_cnt = 0;
    tick(20);
    chk("R6 zero length quiet", hi_cnt, 0);

    // R8: length changed mid-pulse is ignored
    len_v = 8'd4;
    do_load(20);
    while (!trig_o) tick();
    tick();
    len_v = 8'd15;
    tick(8);
    chk("R8 width keeps sampled length", last_width, 4);

    // R7: retrigger every 3 cycles with length 10 keeps pulse high
    len_v = 8'd10;
    do_load(1);
    tick(15);
    lo_cnt = 0;
    tick(20);
    chk("R7 no gap on retrigger", lo_cnt, 0);

    // Long period
    len_v = 8'd2;
    do_load(200);
    tick(420);
    chk("R3 long period", last_interval, 202);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      len_v = 8'($urandom_range(0, 15));
      if ($urandom_range(0, 63) == 0) begin
        load_stb = 1'b1; load_v = PW'($urandom_range(0, 40)) & {(PW-1){1'b1}};
      end else load_stb = 1'b0;
      tick();
    end
    load_stb = 1'b0;

    // Mid-run reset
    rst = 1'b1;
    tick(2);
    chk("R1 trig mid reset", int'(trig_o), 0);
    chk("R1 pulse mid reset", int'(pulse_o), 0);
    rst = 1'b0;
    tick(10);

    chk("R4 no consecutive trigger", consec, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule